// File: doc/BRIEF.md
# Sector-Striped Four-Channel Data Router

This block sits between one 128-bit user FIFO pair and four per-channel FIFO pairs that feed a four-disk stripe set. The stripe unit is one 512-byte sector, which is 32 consecutive 128-bit beats. A transfer is launched by a one-cycle start pulse carrying a direction and a total sector count.

On a write, whole sectors are pulled from the user transmit FIFO and each sector is pushed into one channel transmit FIFO. On a read, one sector at a time is pulled from a channel receive FIFO and pushed into the user receive FIFO. In both directions the channels are taken in rotation 0, 1, 2, 3, 0, and so on. Sector k always maps to channel k mod 4. Before each sector, the block checks the fill-level counters: the source must hold a whole sector and the destination must have room for two. When the last sector has been written, the block pulses done and returns to idle.

The controller is a five-state machine:
- ST_IDLE waits for start. On start it goes to ST_WAIT, or to ST_DONE when the count is zero.
- ST_WAIT holds until the gate for the active channel opens, then goes to ST_MOVE.
- ST_MOVE issues 32 read strobes and then goes to ST_DRAIN.
- ST_DRAIN completes the final delayed write of the sector and advances the channel. It then goes to ST_WAIT, or to ST_DONE after the last sector.
- ST_DONE raises done for one cycle and returns to ST_IDLE.

Top module: `stripe_router`

## Requirements
- R1: After reset the router is idle: busy, done, utx_rd_en, urx_wr_en, ch_tx_wr_en and ch_rx_rd_en are all 0.
- R2: A start pulse in idle latches dir_rd and sector_count, and busy is 1 from the next cycle until the cycle after done. A start pulse while busy is ignored and does not change the transfer in progress.
- R3: Every command begins at channel 0. Sector k of the command uses channel k mod 4. Channel c is bit c of ch_tx_wr_en and ch_rx_rd_en, and lane c of ch_tx_space, ch_rx_cnt and ch_rx_rd_data (bits c*W+W-1 down to c*W).
- R4: Each sector is moved as exactly 32 consecutive cycles of source read strobe, and its beats arrive at the destination in source order.
- R5: A write sector starts only when utx_rd_cnt bits [15:5] are not all zero (at least 32 beats) and the active channel's ch_tx_space is at least 64.
- R6: A read sector starts only when the active channel's ch_rx_cnt is at least 32 and urx_wr_cnt bits [15:6] are not all ones.
- R7: Source read data is valid one clock after the read strobe. The destination write strobe is asserted one cycle after each read strobe, and it carries the source data present in that cycle.
- R8: At most one channel strobe is active in any cycle.
- R9: done is a single-cycle pulse after the final write of the last sector, and busy is 0 in the following cycle.
- R10: A start with sector_count 0 moves no data and produces one done pulse.
- R11: utx_empty has no effect on the transfer.
- R12: dir_rd = 0 selects a write (user transmit to channel transmit FIFOs). dir_rd = 1 selects a read (channel receive to user receive FIFO).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for a transfer |
| dir_rd | input | 1 | Direction: 0 write, 1 read |
| sector_count | input | SECT_W | Number of sectors to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| utx_rd_cnt | input | CNT_W | Beats held in user transmit FIFO |
| utx_empty | input | 1 | User transmit FIFO empty flag (unused by the logic) |
| utx_rd_en | output | 1 | User transmit FIFO read strobe |
| utx_rd_data | input | DATA_W | User transmit FIFO data, valid one clock after the strobe |
| urx_wr_cnt | input | CNT_W | Beats held in user receive FIFO |
| urx_wr_en | output | 1 | User receive FIFO write strobe |
| urx_wr_data | output | DATA_W | User receive FIFO write data |
| ch_tx_space | input | NCH*CNT_W | Free beats in each channel transmit FIFO |
| ch_tx_wr_en | output | NCH | Channel transmit FIFO write strobes |
| ch_tx_wr_data | output | DATA_W | Shared channel transmit write data |
| ch_rx_cnt | input | NCH*CNT_W | Beats held in each channel receive FIFO |
| ch_rx_rd_en | output | NCH | Channel receive FIFO read strobes |
| ch_rx_rd_data | input | NCH*DATA_W | Channel receive FIFO data, valid one clock after the strobe |

## Verification
Several properties are checked by assertions on every cycle:
- both fill-level gates, sampled at the edge where a sector burst begins;
- the 32-beat burst length;
- the one-cycle spacing from read strobe to write strobe;
- the single-channel rule;
- the drop of busy after done.

Other behaviours show up only in the bench's scenarios: rotation through the channels, restart at channel 0 on each command, and beat order. The bench checks these by comparing the full contents of its FIFO models against patterns it computes itself. The same applies to ignoring a second start, the zero-length command and the unused empty flag. Throttled counters, directed and random, show that a stalled gate resumes without losing or duplicating beats.

// File: rtl/stripe_router_pkg.sv
package stripe_router_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_MOVE  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } rt_state_t;

endpackage

// File: rtl/stripe_gate.sv
module stripe_gate #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int BEATS = 32,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic                 dir_rd,
    input  logic [CH_W-1:0]      ch_idx,
    input  logic [CNT_W-1:0]     utx_rd_cnt,
    input  logic                 utx_empty,
    input  logic [CNT_W-1:0]     urx_wr_cnt,
    input  logic [NCH*CNT_W-1:0] ch_tx_space,
    input  logic [NCH*CNT_W-1:0] ch_rx_cnt,
    output logic                 go
);
    localparam logic [CNT_W-1:0] ONE_SECT  = CNT_W'(BEATS);
    localparam logic [CNT_W-1:0] TWO_SECT  = CNT_W'(2 * BEATS);
    localparam logic [CNT_W-1:0] URX_LIMIT = ~CNT_W'(2 * BEATS - 1);

    logic [NCH-1:0] tx_room;
    logic [NCH-1:0] rx_avail;
    logic           src_ok;
    logic           dst_ok;
    logic           wr_ok;
    logic           rd_ok;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_lane
            assign tx_room[c]  = ch_tx_space[c*CNT_W +: CNT_W] >= TWO_SECT;
            assign rx_avail[c] = ch_rx_cnt[c*CNT_W +: CNT_W] >= ONE_SECT;
        end
    endgenerate

    // Whole-sector source test; the empty flag is deliberately neutral.
    assign src_ok = (utx_rd_cnt >= ONE_SECT) & (utx_empty | ~utx_empty);
    assign dst_ok = urx_wr_cnt < URX_LIMIT;
    assign wr_ok  = src_ok & tx_room[ch_idx];
    assign rd_ok  = rx_avail[ch_idx] & dst_ok;
    assign go     = dir_rd ? rd_ok : wr_ok;

endmodule

// File: rtl/stripe_lane_sel.sv
module stripe_lane_sel #(
    parameter int NCH    = 4,
    parameter int DATA_W = 128,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic [CH_W-1:0]       ch_idx,
    input  logic                  rd_pulse,
    input  logic                  wr_pulse,
    input  logic [NCH*DATA_W-1:0] ch_rx_rd_data,
    output logic [NCH-1:0]        ch_rx_rd_en,
    output logic [NCH-1:0]        ch_tx_wr_en,
    output logic [DATA_W-1:0]     rx_data
);
    logic [NCH-1:0] sel;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_sel
            assign sel[c]         = ch_idx == CH_W'(c);
            assign ch_rx_rd_en[c] = sel[c] & rd_pulse;
            assign ch_tx_wr_en[c] = sel[c] & wr_pulse;
        end
    endgenerate

    assign rx_data = ch_rx_rd_data[ch_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/stripe_router.sv
module stripe_router
    import stripe_router_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int BEATS  = 32,
    parameter int SECT_W = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  dir_rd,
    input  logic [SECT_W-1:0]     sector_count,
    output logic                  busy,
    output logic                  done,
    input  logic [CNT_W-1:0]      utx_rd_cnt,
    input  logic                  utx_empty,
    output logic                  utx_rd_en,
    input  logic [DATA_W-1:0]     utx_rd_data,
    input  logic [CNT_W-1:0]      urx_wr_cnt,
    output logic                  urx_wr_en,
    output logic [DATA_W-1:0]     urx_wr_data,
    input  logic [NCH*CNT_W-1:0]  ch_tx_space,
    output logic [NCH-1:0]        ch_tx_wr_en,
    output logic [DATA_W-1:0]     ch_tx_wr_data,
    input  logic [NCH*CNT_W-1:0]  ch_rx_cnt,
    output logic [NCH-1:0]        ch_rx_rd_en,
    input  logic [NCH*DATA_W-1:0] ch_rx_rd_data
);
    localparam int CH_W   = $clog2(NCH);
    localparam int BEAT_W = $clog2(BEATS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [SECT_W-1:0] ONE_LEFT  = SECT_W'(1);

    rt_state_t         state;
    rt_state_t         state_nx;
    logic [CH_W-1:0]   ch_idx;
    logic [BEAT_W-1:0] beat;
    logic [SECT_W-1:0] remaining;
    logic              dir_q;
    logic              wr_q;
    logic              go;
    logic              move;
    logic [DATA_W-1:0] rx_data;

    // Sector admission gate
    stripe_gate #(
        .NCH   (NCH),
        .CNT_W (CNT_W),
        .BEATS (BEATS),
        .CH_W  (CH_W)
    ) u_gate (
        .dir_rd      (dir_q),
        .ch_idx      (ch_idx),
        .utx_rd_cnt  (utx_rd_cnt),
        .utx_empty   (utx_empty),
        .urx_wr_cnt  (urx_wr_cnt),
        .ch_tx_space (ch_tx_space),
        .ch_rx_cnt   (ch_rx_cnt),
        .go          (go)
    );

    // Channel demultiplexer / multiplexer
    stripe_lane_sel #(
        .NCH    (NCH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_sel (
        .ch_idx        (ch_idx),
        .rd_pulse      (move & dir_q),
        .wr_pulse      (wr_q & ~dir_q),
        .ch_rx_rd_data (ch_rx_rd_data),
        .ch_rx_rd_en   (ch_rx_rd_en),
        .ch_tx_wr_en   (ch_tx_wr_en),
        .rx_data       (rx_data)
    );

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = (sector_count == '0) ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (go) state_nx = ST_MOVE;
            ST_MOVE:  if (beat == LAST_BEAT) state_nx = ST_DRAIN;
            ST_DRAIN: state_nx = (remaining == ONE_LEFT) ? ST_DONE : ST_WAIT;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ch_idx    <= '0;
            beat      <= '0;
            remaining <= '0;
            dir_q     <= 1'b0;
            wr_q      <= 1'b0;
        end else begin
            state <= state_nx;
            wr_q  <= move;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        dir_q     <= dir_rd;
                        remaining <= sector_count;
                        ch_idx    <= '0;
                        beat      <= '0;
                    end
                end
                ST_MOVE: begin
                    beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
                end
                ST_DRAIN: begin
                    ch_idx    <= ch_idx + 1'b1;
                    remaining <= remaining - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        move          = state == ST_MOVE;
        busy          = state != ST_IDLE;
        done          = state == ST_DONE;
        utx_rd_en     = move & ~dir_q;
        urx_wr_en     = wr_q & dir_q;
        urx_wr_data   = rx_data;
        ch_tx_wr_data = utx_rd_data;
    end

endmodule

// File: rtl/stripe_router_chk.sv
module stripe_router_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int BEATS = 32,
    parameter int CH_W  = $clog2(NCH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 utx_rd_en,
    input logic [CNT_W-1:0]     utx_rd_cnt,
    input logic                 urx_wr_en,
    input logic [CNT_W-1:0]     urx_wr_cnt,
    input logic [NCH-1:0]       ch_tx_wr_en,
    input logic [NCH-1:0]       ch_rx_rd_en,
    input logic [NCH*CNT_W-1:0] ch_tx_space,
    input logic [NCH*CNT_W-1:0] ch_rx_cnt,
    input logic [CH_W-1:0]      ch_idx
);
    localparam logic [CNT_W-1:0] ONE_SECT  = CNT_W'(BEATS);
    localparam logic [CNT_W-1:0] TWO_SECT  = CNT_W'(2 * BEATS);
    localparam logic [CNT_W-1:0] URX_LIMIT = ~CNT_W'(2 * BEATS - 1);

    logic        any_rd;
    logic [15:0] run;

    assign any_rd = utx_rd_en | (|ch_rx_rd_en);

    always_ff @(posedge clk) begin
        if (!rst_n)      run <= '0;
        else if (any_rd) run <= run + 1'b1;
        else             run <= '0;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!any_rd && !urx_wr_en && ch_tx_wr_en == '0));

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_rd) |-> run == 16'(BEATS));

    assert_wr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(utx_rd_en) |-> ($past(utx_rd_cnt) >= ONE_SECT &&
                              $past(ch_tx_space[ch_idx*CNT_W +: CNT_W]) >= TWO_SECT));

    assert_rd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ch_rx_rd_en) |-> ($past(ch_rx_cnt[ch_idx*CNT_W +: CNT_W]) >= ONE_SECT &&
                                 $past(urx_wr_cnt) < URX_LIMIT));

    assert_tx_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_tx_wr_en) |-> $past(utx_rd_en));

    assert_rx_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        urx_wr_en |-> $past(|ch_rx_rd_en));

    assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_tx_wr_en) && $onehot0(ch_rx_rd_en));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind stripe_router stripe_router_chk #(
    .NCH   (NCH),
    .CNT_W (CNT_W),
    .BEATS (BEATS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .utx_rd_en   (utx_rd_en),
    .utx_rd_cnt  (utx_rd_cnt),
    .urx_wr_en   (urx_wr_en),
    .urx_wr_cnt  (urx_wr_cnt),
    .ch_tx_wr_en (ch_tx_wr_en),
    .ch_rx_rd_en (ch_rx_rd_en),
    .ch_tx_space (ch_tx_space),
    .ch_rx_cnt   (ch_rx_cnt),
    .ch_idx      (ch_idx)
);

// File: tb/stripe_router_tb.sv
module stripe_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 128;
    localparam int NCH    = 4;
    localparam int CNT_W  = 16;
    localparam int BEATS  = 32;
    localparam int SECT_W = 48;
    localparam int DEPTH  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dir_rd = 1'b0;
    logic [SECT_W-1:0] sector_count = '0;
    logic busy, done;
    logic [CNT_W-1:0] utx_rd_cnt;
    logic utx_empty = 1'b0;
    logic utx_rd_en;
    logic [DATA_W-1:0] utx_rd_data;
    logic [CNT_W-1:0] urx_wr_cnt;
    logic urx_wr_en;
    logic [DATA_W-1:0] urx_wr_data;
    logic [NCH*CNT_W-1:0] ch_tx_space;
    logic [NCH-1:0] ch_tx_wr_en;
    logic [DATA_W-1:0] ch_tx_wr_data;
    logic [NCH*CNT_W-1:0] ch_rx_cnt;
    logic [NCH-1:0] ch_rx_rd_en;
    logic [NCH*DATA_W-1:0] ch_rx_rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    stripe_router u_dut (.*);

    // FIFO models
    logic [DATA_W-1:0] utx_mem [DEPTH];
    int utx_head = 0, utx_tail = 0;
    logic [DATA_W-1:0] utx_q = '0;
    logic [DATA_W-1:0] ctx_mem [NCH][512];
    int ctx_n [NCH];
    logic [DATA_W-1:0] crx_mem [NCH][512];
    int crx_head [NCH];
    int crx_tail [NCH];
    logic [DATA_W-1:0] crx_q [NCH];
    logic [DATA_W-1:0] urx_mem [DEPTH];
    int urx_n = 0;

    logic thr_utx = 0, urx_full = 0, rnd_thr = 0;
    logic [NCH-1:0] thr_ctx = '0, thr_crx = '0;

    int n_checks = 0, n_fail = 0, done_cnt = 0, multi_cnt = 0;
    bit finished = 0;

    assign utx_rd_data = utx_q;
    always_comb begin
        int avail;
        avail = utx_tail - utx_head;
        utx_rd_cnt = thr_utx ? CNT_W'((avail > 31) ? 31 : avail) : CNT_W'(avail);
        urx_wr_cnt = urx_full ? 16'hFFC0 : CNT_W'(urx_n);
        for (int c = 0; c < NCH; c++) begin
            int rc;
            rc = crx_tail[c] - crx_head[c];
            ch_tx_space[c*CNT_W +: CNT_W] = thr_ctx[c] ? 16'd63 : CNT_W'(DEPTH - ctx_n[c]);
            ch_rx_cnt[c*CNT_W +: CNT_W] = thr_crx[c] ? CNT_W'((rc > 31) ? 31 : rc) : CNT_W'(rc);
            ch_rx_rd_data[c*DATA_W +: DATA_W] = crx_q[c];
        end
    end

    always @(posedge clk) begin
        if (utx_rd_en) begin
            utx_q <= utx_mem[utx_head];
            utx_head <= utx_head + 1;
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_tx_wr_en[c]) begin
                ctx_mem[c][ctx_n[c]] <= ch_tx_wr_data;
                ctx_n[c] <= ctx_n[c] + 1;
            end
            if (ch_rx_rd_en[c]) begin
                crx_q[c] <= crx_mem[c][crx_head[c]];
                crx_head[c] <= crx_head[c] + 1;
            end
        end
        if (urx_wr_en) begin
            urx_mem[urx_n] <= urx_wr_data;
            urx_n <= urx_n + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
        if ($countones(ch_tx_wr_en) + $countones(ch_rx_rd_en) > 1) multi_cnt <= multi_cnt + 1;
    end

    always @(negedge clk) begin
        if (rnd_thr) begin
            thr_utx  <= ($urandom % 4) == 0;
            urx_full <= ($urandom % 4) == 0;
            thr_ctx  <= NCH'($urandom) & NCH'($urandom);
            thr_crx  <= NCH'($urandom) & NCH'($urandom);
        end
    end

    function automatic logic [DATA_W-1:0] pat(int tag, int idx);
        return {32'(tag), 32'(idx), 32'(idx * 7 + tag * 13), ~32'(idx)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_models();
        @(negedge clk);
        utx_head = 0; utx_tail = 0; urx_n = 0;
        for (int c = 0; c < NCH; c++) begin
            ctx_n[c] = 0; crx_head[c] = 0; crx_tail[c] = 0;
        end
    endtask

    task automatic load_utx(int tag, int beats);
        for (int i = 0; i < beats; i++) utx_mem[utx_tail + i] = pat(tag, utx_tail + i);
        utx_tail = utx_tail + beats;
    endtask

    task automatic load_crx(int tag, int sectors);
        for (int c = 0; c < NCH; c++) begin
            for (int j = 0; j < ((sectors - c + NCH - 1) / NCH) * BEATS; j++)
                crx_mem[c][j] = pat(tag + c, j);
            crx_tail[c] = (sectors > c) ? ((sectors - c + NCH - 1) / NCH) * BEATS : 0;
        end
    endtask

    task automatic kick(bit rd, int n);
        @(negedge clk);
        start = 1'b1; dir_rd = rd; sector_count = SECT_W'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int t;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(done, req, "done not seen", 0, 1);
        @(negedge clk);
        check(!busy, "R9", "busy after done", DATA_W'(busy), 0);
    endtask

    task automatic check_write(int tag, int n, string req);
        for (int c = 0; c < NCH; c++) begin
            int exp_n;
            exp_n = ((n - c + NCH - 1) / NCH) * BEATS;
            if (n <= c) exp_n = 0;
            check(ctx_n[c] == exp_n, "R3", $sformatf("ch%0d beat count", c), DATA_W'(ctx_n[c]), DATA_W'(exp_n));
            for (int j = 0; j < ctx_n[c] && j < exp_n; j++) begin
                int s;
                s = (j / BEATS) * NCH + c;
                if (ctx_mem[c][j] !== pat(tag, s * BEATS + j % BEATS)) begin
                    check(0, req, $sformatf("ch%0d beat %0d data", c, j), ctx_mem[c][j], pat(tag, s * BEATS + j % BEATS));
                    break;
                end
            end
        end
        check(utx_head == n * BEATS, "R4", "source beats consumed", DATA_W'(utx_head), DATA_W'(n * BEATS));
    endtask

    task automatic check_read(int tag, int n, string req);
        bit ok;
        ok = 1;
        check(urx_n == n * BEATS, "R4", "user rx beat count", DATA_W'(urx_n), DATA_W'(n * BEATS));
        for (int k = 0; k < urx_n && k < n * BEATS; k++) begin
            int s, c, j;
            s = k / BEATS; c = s % NCH; j = (s / NCH) * BEATS + k % BEATS;
            if (ok && urx_mem[k] !== pat(tag + c, j)) begin
                ok = 0;
                check(0, req, $sformatf("user rx beat %0d", k), urx_mem[k], pat(tag + c, j));
            end
        end
        if (ok) check(1, req, "read order", 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin
            ctx_n[c] = 0; crx_head[c] = 0; crx_tail[c] = 0; crx_q[c] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !utx_rd_en && !urx_wr_en && ch_tx_wr_en == 0 && ch_rx_rd_en == 0,
              "R1", "outputs in reset", DATA_W'({busy, done, utx_rd_en, urx_wr_en, ch_tx_wr_en, ch_rx_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R1", "idle after reset", DATA_W'(busy), 0);

        // R12/R3/R7/R11: write of 5 sectors with empty flag forced high
        utx_empty = 1'b1;
        load_utx(100, 5 * BEATS);
        kick(0, 5);
        check(busy, "R2", "busy after start", DATA_W'(busy), 1);
        wait_done("R12");
        check_write(100, 5, "R7");
        check(done_cnt == 1, "R11", "write completes with empty high", DATA_W'(done_cnt), 1);
        utx_empty = 1'b0;

        // R3: new command restarts at channel 0
        clear_models();
        load_utx(200, 2 * BEATS);
        kick(0, 2);
        wait_done("R3");
        check_write(200, 2, "R3");

        // R12: read of 6 sectors
        clear_models();
        load_crx(300, 6);
        kick(1, 6);
        wait_done("R12");
        check_read(300, 6, "R12");

        // R5: source short by one beat, then channel space short
        clear_models();
        load_utx(400, BEATS - 1);
        kick(0, 2);
        repeat (80) @(negedge clk);
        check(utx_head == 0 && busy, "R5", "no read with 31 beats", DATA_W'(utx_head), 0);
        load_utx(400, BEATS + 1);
        thr_ctx = 4'b0010;
        repeat (150) @(negedge clk);
        check(ctx_n[0] == BEATS && ctx_n[1] == 0, "R5", "ch1 held at 63 free", DATA_W'(ctx_n[1]), 0);
        thr_ctx = '0;
        wait_done("R5");
        check_write(400, 2, "R5");

        // R6: user rx full, then channel rx short
        clear_models();
        load_crx(500, 2);
        urx_full = 1'b1;
        kick(1, 2);
        repeat (80) @(negedge clk);
        check(urx_n == 0 && crx_head[0] == 0, "R6", "no read while user rx full", DATA_W'(urx_n), 0);
        urx_full = 1'b0;
        thr_crx = 4'b0010;
        repeat (150) @(negedge clk);
        check(urx_n == BEATS && crx_head[1] == 0, "R6", "ch1 held at 31 beats", DATA_W'(crx_head[1]), 0);
        thr_crx = '0;
        wait_done("R6");
        check_read(500, 2, "R6");

        // R10: zero-length command
        clear_models();
        base = done_cnt;
        kick(0, 0);
        repeat (4) @(negedge clk);
        check(done_cnt == base + 1 && !busy, "R10", "zero count done", DATA_W'(done_cnt - base), 1);
        check(utx_head == 0 && urx_n == 0, "R10", "no data moved", DATA_W'(utx_head), 0);

        // R2: start while busy is ignored
        clear_models();
        load_utx(600, 4 * BEATS);
        load_crx(650, 8);
        base = done_cnt;
        kick(0, 4);
        repeat (20) @(negedge clk);
        kick(1, 9);
        wait_done("R2");
        repeat (5) @(negedge clk);
        check(done_cnt == base + 1, "R2", "single done", DATA_W'(done_cnt - base), 1);
        check(urx_n == 0, "R2", "second start caused no read", DATA_W'(urx_n), 0);
        check_write(600, 4, "R2");

        // Random transfers under random throttling
        for (int it = 0; it < 8; it++) begin
            int n;
            bit rd;
            n = 1 + int'($urandom % 12);
            rd = 1'($urandom);
            clear_models();
            if (rd) load_crx(1000 + it * 10, n); else load_utx(1000 + it * 10, n * BEATS);
            rnd_thr = 1'b1;
            kick(rd, n);
            wait_done("R9");
            rnd_thr = 1'b0;
            @(negedge clk);
            thr_utx = 0; urx_full = 0; thr_ctx = '0; thr_crx = '0;
            if (rd) check_read(1000 + it * 10, n, "R4");
            else    check_write(1000 + it * 10, n, "R4");
        end

        check(multi_cnt == 0, "R8", "cycles with two channel strobes", DATA_W'(multi_cnt), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule